// File: doc/BRIEF.md
# Transmit Edge Stretch Compensator

This block sits on the transmit serial path, immediately ahead of the output driver. It reduces intersymbol interference in the time domain. It does not lower the amplitude of repeated bits. Instead, when the data changes level, it moves that change earlier, so that the new level starts a programmable number of slots before the nominal bit edge.

The output is oversampled: every serial bit becomes `SLOTS` consecutive output slots. A slot advances on each clock where `slot_en` is high. The block keeps a short history of the bits it has accepted: the bit now on the line, the bit that follows it, and whether the edge into the current bit was already advanced. From that history it decides, slot by slot, which level to drive.

A bit is accepted at the first slot of each bit period. It reaches the line one full bit period later. The stretch amount is taken at the same moment as the bit, so it stays fixed for the whole period.

Top module: `isi_edge_stretch`

## Requirements
- R1: After reset `drive` is 0, and the first `slot_en` after reset is a bit boundary. Every `SLOTS`-th enable after that is also a bit boundary.
- R2: When a bit equals the bit that follows it, `drive` carries that bit's level in all `SLOTS` of its slots.
- R3: When the next bit differs from the current bit, the stretch S is non-zero and the edge is not suppressed, the last S slots of the current bit carry the next bit's level. The first `SLOTS`-S slots carry the current level.
- R4: With a stretch setting of 0, `drive` equals the input bit stream delayed by exactly one bit period, slot for slot.
- R5: A stretch setting larger than `SLOTS`/2 (integer division) acts exactly like `SLOTS`/2.
- R6: An edge directly after an edge that was stretched is not stretched. As a result, no level on `drive` lasts fewer than `SLOTS`/2 slots.
- R7: `bit_in` and `stretch` are sampled only on the boundary enable. The bit sampled on enable number e (counted from 0 after reset) owns the nominal slots shown after enables e+`SLOTS` through e+2·`SLOTS`-1. Values presented on other enables have no effect.
- R8: `drive` changes only on a clock edge at which `slot_en` is high. It holds its value through idle clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | 1 | Advances the output by one slot |
| bit_in | input | 1 | Serial data bit, sampled at the bit boundary |
| stretch | input | STRETCH_W | Number of slots by which an edge is advanced |
| drive | output | 1 | Oversampled line level for the output driver |

## Verification
Each slot value appears on `drive` at the clock edge that carries its `slot_en`. The bench therefore compares `drive` on the falling edge right after every enable. On each idle clock between enables it checks that `drive` is unchanged. A bit takes effect `SLOTS` enables after its boundary enable, whatever the number of idle clocks in between. The bench model counts enables, not clocks, and predicts the slot value for each enable from the bits and stretch values it presented on boundary enables. On non-boundary enables the bench drives random `bit_in` and `stretch` values, so that any sampling outside the boundary would show up as a mismatch.

// File: rtl/isi_pkg.sv
package isi_pkg;
   // Bit history kept per bit period.
   typedef struct packed {
      logic supp;   // edge into the current bit was advanced
      logic nxt;    // bit following the current one
      logic cur;    // bit presently on the line
   } hist_t;
endpackage

// File: rtl/isi_slot_timer.sv
module isi_slot_timer #(
   parameter int SLOTS = 8,
   localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slot_en,
   output logic [IDX_W-1:0] idx_q,
   output logic [IDX_W-1:0] idx_d,
   output logic             bnd
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

   assign bnd = slot_en && (idx_q == LAST);

   always_comb begin
      idx_d = idx_q;
      if (slot_en) idx_d = (idx_q == LAST) ? '0 : idx_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) idx_q <= LAST;
      else        idx_q <= idx_d;
   end

   // R7: the index never leaves its range, so boundaries recur every SLOTS enables
   a_r7_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= LAST);
   a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      bnd |=> idx_q == '0);
endmodule

// File: rtl/isi_bit_history.sv
module isi_bit_history
   import isi_pkg::*;
#(
   parameter int SLOTS     = 8,
   parameter int STRETCH_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bnd,
   input  logic                 bit_in,
   input  logic [STRETCH_W-1:0] stretch,
   output hist_t                h_q,
   output hist_t                h_d,
   output logic [STRETCH_W-1:0] s_q,
   output logic [STRETCH_W-1:0] s_d
);
   localparam int HALF    = SLOTS / 2;
   localparam int MAX_SET = (1 << STRETCH_W) - 1;

   logic [STRETCH_W-1:0] s_lim;
   logic                 applied;

   generate
      if (MAX_SET > HALF) begin : g_clamp
         localparam logic [STRETCH_W-1:0] HALF_S = STRETCH_W'(HALF);
         assign s_lim = (stretch > HALF_S) ? HALF_S : stretch;
      end else begin : g_pass
         assign s_lim = stretch;
      end
   endgenerate

   // the edge at the end of the current period is being advanced
   assign applied = (h_q.cur != h_q.nxt) && (s_q != '0) && !h_q.supp;

   always_comb begin
      h_d = h_q;
      s_d = s_q;
      if (bnd) begin
         h_d.supp = applied;
         h_d.cur  = h_q.nxt;
         h_d.nxt  = bit_in;
         s_d      = s_lim;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         h_q <= '0;
         s_q <= '0;
      end else begin
         h_q <= h_d;
         s_q <= s_d;
      end
   end

   // R5: the stretch in use never exceeds half a bit
   a_r5_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      int'(s_q) <= HALF);
   // R6: two advanced edges never follow one another
   a_r6_no_double: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd && h_q.supp) |=> !h_q.supp);
   // R7: history moves only at a boundary
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bnd |=> $stable(h_q) && $stable(s_q));
endmodule

// File: rtl/isi_edge_shaper.sv
module isi_edge_shaper
   import isi_pkg::*;
#(
   parameter int SLOTS     = 8,
   parameter int STRETCH_W = 3,
   localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
   localparam int RUN_W = $clog2(SLOTS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 slot_en,
   input  logic [IDX_W-1:0]     idx_q,
   input  logic [IDX_W-1:0]     idx_d,
   input  hist_t                h_q,
   input  hist_t                h_d,
   input  logic [STRETCH_W-1:0] s_q,
   input  logic [STRETCH_W-1:0] s_d,
   output logic                 drive
);
   localparam int HALF = SLOTS / 2;
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(SLOTS);

   logic             nxt_val;
   logic             early;
   logic [RUN_W-1:0] run_cnt;

   // the slot about to be shown lies within the advanced window
   assign early   = (h_d.cur != h_d.nxt) && !h_d.supp && (s_d != '0)
                    && (int'(idx_d) >= SLOTS - int'(s_d));
   assign nxt_val = early ? h_d.nxt : h_d.cur;

   always_ff @(posedge clk) begin
      if (!rst_n)       drive <= 1'b0;
      else if (slot_en) drive <= nxt_val;
   end

   // run length of the present level, in slots, saturating at SLOTS
   always_ff @(posedge clk) begin
      if (!rst_n) run_cnt <= RUN_MAX;
      else if (slot_en) begin
         if (nxt_val != drive)      run_cnt <= RUN_W'(1);
         else if (run_cnt < RUN_MAX) run_cnt <= run_cnt + 1'b1;
      end
   end

   // R8: the line only moves on slot enables
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_en |=> $stable(drive));
   // R6: a level is never cut shorter than half a bit
   a_r6_min_width: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_en && nxt_val != drive) |-> int'(run_cnt) >= HALF);
   // R4: with no stretch the line shows the current bit
   a_r4_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (s_q == '0) |-> drive == h_q.cur);
   // R3: a deviating level is the next bit, inside the final window only
   a_r3_lead_only: assert property (@(posedge clk) disable iff (!rst_n)
      (drive != h_q.cur) |-> (drive == h_q.nxt)
                             && (int'(idx_q) >= SLOTS - int'(s_q)));
endmodule

// File: rtl/isi_edge_stretch.sv
module isi_edge_stretch
   import isi_pkg::*;
#(
   parameter int SLOTS     = 8,
   parameter int STRETCH_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 slot_en,
   input  logic                 bit_in,
   input  logic [STRETCH_W-1:0] stretch,
   output logic                 drive
);
   localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

   generate
      if (SLOTS < 2) begin : g_bad_slots
         $error("SLOTS must be at least 2");
      end
      if (STRETCH_W < 1) begin : g_bad_width
         $error("STRETCH_W must be at least 1");
      end
   endgenerate

   logic [IDX_W-1:0]     idx_q, idx_d;
   logic                 bnd;
   hist_t                h_q, h_d;
   logic [STRETCH_W-1:0] s_q, s_d;

   isi_slot_timer #(.SLOTS(SLOTS)) u_timer (
      .clk(clk), .rst_n(rst_n), .slot_en(slot_en),
      .idx_q(idx_q), .idx_d(idx_d), .bnd(bnd)
   );

   isi_bit_history #(.SLOTS(SLOTS), .STRETCH_W(STRETCH_W)) u_hist (
      .clk(clk), .rst_n(rst_n), .bnd(bnd), .bit_in(bit_in),
      .stretch(stretch), .h_q(h_q), .h_d(h_d), .s_q(s_q), .s_d(s_d)
   );

   isi_edge_shaper #(.SLOTS(SLOTS), .STRETCH_W(STRETCH_W)) u_shape (
      .clk(clk), .rst_n(rst_n), .slot_en(slot_en),
      .idx_q(idx_q), .idx_d(idx_d), .h_q(h_q), .h_d(h_d),
      .s_q(s_q), .s_d(s_d), .drive(drive)
   );

   // R1: the line is low while reset is held
   a_r1_reset: assert property (@(posedge clk)
      !rst_n |=> !drive);
endmodule

// File: tb/isi_edge_stretch_tb.sv
`timescale 1ns/1ps
module isi_edge_stretch_tb;
   localparam int SLOTS = 8;
   localparam int SW    = 3;
   localparam int HALF  = SLOTS / 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          slot_en = 1'b0;
   logic          bit_in = 1'b0;
   logic [SW-1:0] stretch = '0;
   logic          drive;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 0;

   // reference state, built from the requirements
   int  m_idx  = SLOTS - 1;
   bit  m_cur  = 0, m_nxt = 0, m_supp = 0;
   int  m_s    = 0;
   bit  m_exp  = 0;

   always #2 clk = ~clk;

   isi_edge_stretch #(.SLOTS(SLOTS), .STRETCH_W(SW)) u_dut (
      .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .bit_in(bit_in),
      .stretch(stretch), .drive(drive)
   );

   function automatic bit exp_level(int idx, bit cur, bit nxt, int s, bit supp);
      if (cur != nxt && !supp && s != 0 && idx >= SLOTS - s) return nxt;
      return cur;
   endfunction

   task automatic check(input bit act, input bit exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: drive=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   // one slot: call at a falling edge, returns at a falling edge
   task automatic slot(input bit b, input int st, input int gap, input string tag);
      bit app;
      bit_in  = b;
      stretch = SW'(st);
      slot_en = 1'b1;
      if (m_idx == SLOTS - 1) begin
         app    = (m_cur != m_nxt) && (m_s != 0) && !m_supp;
         m_supp = app;
         m_cur  = m_nxt;
         m_nxt  = b;
         m_s    = (st > HALF) ? HALF : st;
         m_idx  = 0;
      end else begin
         m_idx++;
      end
      m_exp = exp_level(m_idx, m_cur, m_nxt, m_s, m_supp);
      @(posedge clk);
      @(negedge clk);
      check(drive, m_exp, tag);
      if (gap > 0) begin
         slot_en = 1'b0;
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            check(drive, m_exp, "R8");
         end
      end
   endtask

   // one bit period; other slots present random data that must be ignored (R7)
   task automatic send_bit(input bit b, input int st, input int maxgap, input string tag);
      for (int k = 0; k < SLOTS; k++) begin
         int gap;
         gap = (maxgap == 0) ? 0 : int'($urandom_range(maxgap, 0));
         if (k == 0) slot(b, st, gap, tag);
         else        slot(1'($urandom_range(1, 0)), int'($urandom_range(7, 0)), gap, tag);
      end
   endtask

   initial begin
      void'($urandom(32'h5eed_1357));
      repeat (3) @(negedge clk);
      check(drive, 1'b0, "R1");
      rst_n = 1'b1;
      @(negedge clk);
      check(drive, 1'b0, "R1");

      // R4 and R7: zero stretch, random bits, one-bit-period delay
      for (int i = 0; i < 24; i++) send_bit(1'($urandom_range(1, 0)), 0, 1, "R4_R7");

      // R2 and R3: steady runs and isolated edges with stretch 3
      send_bit(0, 3, 0, "R2"); send_bit(0, 3, 0, "R2");
      send_bit(1, 3, 0, "R3"); send_bit(1, 3, 0, "R2"); send_bit(1, 3, 0, "R2");
      send_bit(0, 3, 2, "R3"); send_bit(0, 3, 0, "R2"); send_bit(0, 3, 0, "R2");

      // R6: single-bit pulses at full stretch keep at least half a bit
      send_bit(1, 4, 0, "R6"); send_bit(0, 4, 0, "R6"); send_bit(1, 4, 0, "R6");
      send_bit(0, 4, 0, "R6"); send_bit(0, 4, 0, "R6"); send_bit(0, 4, 0, "R6");

      // R5: settings above half a bit behave as half a bit
      send_bit(1, 7, 0, "R5"); send_bit(1, 7, 0, "R5"); send_bit(0, 6, 1, "R5");
      send_bit(0, 5, 0, "R5"); send_bit(1, 7, 0, "R5"); send_bit(1, 0, 0, "R5");

      // mixed random traffic
      for (int i = 0; i < 300; i++)
         send_bit(1'($urandom_range(1, 0)), int'($urandom_range(7, 0)), 2, "R3_R6_R7");

      // flush and check the line settles to the last bit
      send_bit(0, 2, 0, "R7"); send_bit(0, 2, 0, "R7"); send_bit(0, 2, 0, "R7");
      slot_en = 1'b0;
      repeat (4) begin
         @(negedge clk);
         check(drive, m_exp, "R8");
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule